// File: doc/BRIEF.md
# SPI-Mode Serial Port Controller

This block is a synchronous serial port that runs the SPI protocol in either the bus master or the bus slave role. A simple register port sets it up. Software uses that port to pick the clock polarity and phase, set the bit rate through an even prescaler and a rate divider, select the role, and turn on an internal loopback path. The same port moves 8-bit words through single-word transmit and receive holding registers.

As master, the block starts a frame when software writes the transmit register. It pulls the select line low and shifts eight bits out on MOSI, most significant bit first, while it samples MISO. It then releases the select line and raises a done flag. As slave, it passes the external clock, select and MOSI lines through two-flop synchronizers into the system clock domain. It shifts the held transmit word out on MISO and gathers the incoming word from MOSI. A slave can be told never to drive MISO. The role bit cannot change while the port is enabled.

Register map, as word addresses on the register port:
- Address 0 is the mode register: bit 0 is the idle clock level, bit 1 is the capture phase, and bits 15:8 are the rate divider.
- Address 1 is the control register: bit 0 is loopback, bit 1 is enable, bit 2 is the slave role, and bit 3 is slave output disable.
- Address 2 is the prescaler.
- Address 3 is data: a write fills the transmit register and a read returns the receive register.
- Address 4 is status: bit 0 is done and bit 1 is busy.

Top module: `spi_port_ctrl`

## Requirements
- R1: After reset every register reads 0, except the prescaler, which reads 2. In the same state ssel_o is 1, miso_oe is 0, mst_oe is 0 and done is 0.
- R2: A prescaler write stores the written value with bit 0 cleared. A write whose bits 7:1 are all zero stores 2.
- R3: Unused bits read as 0 and ignore writes. These are bits 15:4 of the control register and bits 7:2 of the mode register.
- R4: A data write while the port is an enabled, idle master pulls ssel_o low and sends the 8-bit word on mosi_o, most significant bit first. The port then raises ssel_o, sets done, and a data read returns the captured word.
- R5: Between frames sclk_o sits at the idle level (mode bit 0). With phase 0 the input is captured on edges that leave the idle level. With phase 1 it is captured on edges that return to it.
- R6: Each half period of sclk_o in a master frame lasts (prescaler/2)*(divider+1) clock cycles.
- R7: With loopback set, the receiver takes the port's own output: mosi_o in master mode and miso_o in slave mode. The external input pin is ignored.
- R8: A control write while the port is enabled leaves the slave role bit unchanged. While the port is disabled, such a write updates it.
- R9: An enabled slave sends the held transmit word on miso_o, most significant bit first, while ssel_i is low. It captures mosi_i on the capture edges of sclk_i, and after 8 bits it sets done and makes the word readable.
- R10: With slave output disable set, miso_oe stays 0 for the whole frame.
- R11: While the port is disabled, a data write starts no frame, ssel_o stays 1, miso_oe stays 0 and done stays 0.
- R12: A master without loopback captures the level on miso_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the bit rate is derived from it |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data for reg_addr |
| done | output | 1 | A received word is ready to read |
| sclk_o | output | 1 | Serial clock driven in master mode |
| mosi_o | output | 1 | Serial data out in master mode |
| ssel_o | output | 1 | Select out in master mode, active low |
| mst_oe | output | 1 | Enable for the master-driven lines |
| sclk_i | input | 1 | Serial clock in slave mode |
| ssel_i | input | 1 | Select in slave mode, active low |
| mosi_i | input | 1 | Serial data in slave mode |
| miso_i | input | 1 | Serial data in master mode |
| miso_o | output | 1 | Serial data out in slave mode |
| miso_oe | output | 1 | Output enable for miso_o |

## Verification
The bench builds the block with its default parameters: 8-bit frames, 2-stage synchronizers and a 16-bit half-period counter. In master mode it runs all four polarity and phase combinations at the fastest legal rate, where the prescaler is 2 and the divider is 0. It also runs one slower setting, prescaler 4 with divider 2, to measure the 6-cycle half period. Slave frames are driven at 16 clock cycles per bit, which exercises the synchronizer latency without coming near the lower rate limit.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 3;
  localparam int RATE_W = 8;

  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] A_PSC  = 3'd2;
  localparam logic [ADDR_W-1:0] A_DATA = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;

  typedef struct packed {
    logic              loop;
    logic              en;
    logic              slave;
    logic              odis;
    logic              pol;
    logic              pha;
    logic [RATE_W-1:0] scr;
    logic [RATE_W-1:0] psc;
  } cfg_t;
endpackage

// File: rtl/spi_port_regs.sv
module spi_port_regs
  import spi_port_pkg::*;
#(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [REG_W-1:0]   wdata,
  output logic [REG_W-1:0]   rdata,
  input  logic               busy,
  input  logic               frame_done,
  input  logic [FRAME_W-1:0] rx_in,
  output cfg_t               cfg,
  output logic [FRAME_W-1:0] tx_hold,
  output logic               tx_load,
  output logic               done
);
  logic [FRAME_W-1:0] rx_q;
  logic [REG_W-1:0]   rd_next;
  logic [RATE_W-2:0]  psc_half;

  assign psc_half = wdata[RATE_W-1:1];

  always_comb begin
    rd_next = '0;
    case (addr)
      A_MODE:  rd_next = {cfg.scr, 6'b0, cfg.pha, cfg.pol};
      A_CTRL:  rd_next = {12'b0, cfg.odis, cfg.slave, cfg.en, cfg.loop};
      A_PSC:   rd_next = REG_W'(cfg.psc);
      A_DATA:  rd_next = REG_W'(rx_q);
      A_STAT:  rd_next = {14'b0, busy, done};
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg     <= '0;
      cfg.psc <= RATE_W'(2);
      tx_hold <= '0;
      tx_load <= 1'b0;
      rx_q    <= '0;
      done    <= 1'b0;
      rdata   <= '0;
    end else begin
      rdata   <= rd_next;
      tx_load <= 1'b0;
      if (frame_done) begin
        rx_q <= rx_in;
        done <= 1'b1;
      end
      if (wr) begin
        case (addr)
          A_MODE: begin
            cfg.scr <= wdata[15:8];
            cfg.pha <= wdata[1];
            cfg.pol <= wdata[0];
          end
          A_CTRL: begin
            cfg.loop <= wdata[0];
            cfg.en   <= wdata[1];
            if (!cfg.en) cfg.slave <= wdata[2];
            cfg.odis <= wdata[3];
          end
          A_PSC: cfg.psc <= (psc_half == '0) ? RATE_W'(2) : {psc_half, 1'b0};
          A_DATA: begin
            tx_hold <= wdata[FRAME_W-1:0];
            tx_load <= 1'b1;
            done    <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_port_master.sv
module spi_port_master
  import spi_port_pkg::*;
#(
  parameter int FRAME_W = 8,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  cfg_t               cfg,
  input  logic               start,
  input  logic [FRAME_W-1:0] tx_byte,
  input  logic               miso_i,
  output logic               sclk_o,
  output logic               mosi_o,
  output logic               ssel_o,
  output logic               busy,
  output logic               frame_done,
  output logic [FRAME_W-1:0] rx_byte
);
  localparam int EDGES = 2 * FRAME_W;
  localparam int EW    = $clog2(EDGES + 1);
  localparam int BW    = $clog2(FRAME_W + 1);

  logic             active;
  logic [CNT_W-1:0] half_len;
  logic [CNT_W-1:0] cnt;
  logic [EW-1:0]    edge_n;
  logic [BW-1:0]    bits;
  logic [FRAME_W-1:0] tx_sh, rx_sh;
  logic             din;

  assign active   = cfg.en & ~cfg.slave;
  assign half_len = CNT_W'(cfg.psc[RATE_W-1:1]) * (CNT_W'(cfg.scr) + CNT_W'(1));
  assign mosi_o   = tx_sh[FRAME_W-1] & busy;
  assign din      = cfg.loop ? mosi_o : miso_i;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      busy       <= 1'b0;
      ssel_o     <= 1'b1;
      sclk_o     <= cfg.pol;
      cnt        <= '0;
      edge_n     <= '0;
      bits       <= '0;
      frame_done <= 1'b0;
      if (rst) begin
        tx_sh   <= '0;
        rx_sh   <= '0;
        rx_byte <= '0;
      end
    end else begin
      frame_done <= 1'b0;
      if (!busy) begin
        sclk_o <= cfg.pol;
        if (start) begin
          busy   <= 1'b1;
          ssel_o <= 1'b0;
          tx_sh  <= tx_byte;
          cnt    <= '0;
          edge_n <= '0;
          bits   <= '0;
        end
      end else if (cnt == half_len - CNT_W'(1)) begin
        cnt <= '0;
        if (edge_n == EW'(EDGES)) begin
          busy       <= 1'b0;
          ssel_o     <= 1'b1;
          frame_done <= 1'b1;
          rx_byte    <= rx_sh;
        end else begin
          edge_n <= edge_n + EW'(1);
          sclk_o <= ~sclk_o;
          if ((sclk_o == cfg.pol) ^ cfg.pha) begin
            rx_sh <= {rx_sh[FRAME_W-2:0], din};
            bits  <= bits + BW'(1);
          end else if (bits != '0 && bits != BW'(FRAME_W)) begin
            tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
          end
        end
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/spi_port_slave.sv
module spi_port_slave
  import spi_port_pkg::*;
#(
  parameter int FRAME_W = 8,
  parameter int SYNC    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  cfg_t               cfg,
  input  logic [FRAME_W-1:0] tx_byte,
  input  logic               sclk_i,
  input  logic               ssel_i,
  input  logic               mosi_i,
  output logic               miso_o,
  output logic               miso_oe,
  output logic               frame_done,
  output logic [FRAME_W-1:0] rx_byte
);
  localparam int          BW        = $clog2(FRAME_W + 1);
  localparam logic [2:0]  SYNC_INIT = 3'b010;

  logic [2:0] raw, synced;
  logic       sclk_s, ssel_s, mosi_s;
  logic       sclk_p, ssel_p;
  logic       active, din;
  logic [BW-1:0]      bits;
  logic [FRAME_W-1:0] sh, rx_sh;

  assign raw = {mosi_i, ssel_i, sclk_i};

  for (genvar g = 0; g < 3; g++) begin : g_sync
    logic [SYNC-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {SYNC{SYNC_INIT[g]}};
      else     chain <= {chain[SYNC-2:0], raw[g]};
    end
    assign synced[g] = chain[SYNC-1];
  end

  assign sclk_s = synced[0];
  assign ssel_s = synced[1];
  assign mosi_s = synced[2];
  assign active = cfg.en & cfg.slave;
  assign miso_o = sh[FRAME_W-1];
  assign din    = cfg.loop ? miso_o : mosi_s;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      sclk_p     <= sclk_s;
      ssel_p     <= 1'b1;
      bits       <= '0;
      miso_oe    <= 1'b0;
      frame_done <= 1'b0;
      if (rst) begin
        sh      <= '0;
        rx_sh   <= '0;
        rx_byte <= '0;
      end
    end else begin
      frame_done <= 1'b0;
      sclk_p     <= sclk_s;
      ssel_p     <= ssel_s;
      miso_oe    <= ~ssel_s & ~cfg.odis;
      if (ssel_p && !ssel_s) begin
        sh   <= tx_byte;
        bits <= '0;
      end else if (!ssel_s && sclk_s != sclk_p) begin
        if ((sclk_p == cfg.pol) ^ cfg.pha) begin
          if (bits != BW'(FRAME_W)) begin
            rx_sh <= {rx_sh[FRAME_W-2:0], din};
            bits  <= bits + BW'(1);
            if (bits == BW'(FRAME_W - 1)) begin
              frame_done <= 1'b1;
              rx_byte    <= {rx_sh[FRAME_W-2:0], din};
            end
          end
        end else if (bits != '0) begin
          sh <= {sh[FRAME_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
#(
  parameter int FRAME_W = 8,
  parameter int SYNC    = 2,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              done,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              ssel_o,
  output logic              mst_oe,
  input  logic              sclk_i,
  input  logic              ssel_i,
  input  logic              mosi_i,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe
);
  cfg_t               cfg;
  logic [FRAME_W-1:0] tx_hold, m_rx, s_rx, rx_sel;
  logic               tx_load, m_busy, m_done, s_done;

  assign rx_sel = cfg.slave ? s_rx : m_rx;
  assign mst_oe = cfg.en & ~cfg.slave;

  spi_port_regs #(.FRAME_W(FRAME_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(m_busy), .frame_done(m_done | s_done),
    .rx_in(rx_sel), .cfg(cfg), .tx_hold(tx_hold), .tx_load(tx_load), .done(done)
  );

  spi_port_master #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_master (
    .clk(clk), .rst(rst), .cfg(cfg), .start(tx_load), .tx_byte(tx_hold),
    .miso_i(miso_i), .sclk_o(sclk_o), .mosi_o(mosi_o), .ssel_o(ssel_o),
    .busy(m_busy), .frame_done(m_done), .rx_byte(m_rx)
  );

  spi_port_slave #(.FRAME_W(FRAME_W), .SYNC(SYNC)) u_slave (
    .clk(clk), .rst(rst), .cfg(cfg), .tx_byte(tx_hold), .sclk_i(sclk_i),
    .ssel_i(ssel_i), .mosi_i(mosi_i), .miso_o(miso_o), .miso_oe(miso_oe),
    .frame_done(s_done), .rx_byte(s_rx)
  );
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk
  import spi_port_pkg::*;
(
  input logic clk,
  input logic rst,
  input cfg_t cfg,
  input logic ssel_o,
  input logic miso_oe
);
  // R11
  disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg.en && $past(!cfg.en)) |-> (ssel_o && !miso_oe));

  // R10
  odis_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg.odis && $past(cfg.odis)) |-> !miso_oe);

  // R8
  role_lock_chk: assert property (@(posedge clk) disable iff (rst)
    cfg.en |=> $stable(cfg.slave));

  // R2
  psc_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg.psc[0] == 1'b0) && (cfg.psc >= RATE_W'(2)));

  // R4
  ssel_master_chk: assert property (@(posedge clk) disable iff (rst)
    !ssel_o |-> $past(cfg.en && !cfg.slave));
endmodule

bind spi_port_ctrl spi_port_chk u_chk (
  .clk(clk), .rst(rst), .cfg(cfg), .ssel_o(ssel_o), .miso_oe(miso_oe)
);

// File: tb/tb_spi_port_ctrl.sv
module tb_spi_port_ctrl;
  logic        clk = 1'b0, rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic        done, sclk_o, mosi_o, ssel_o, mst_oe, miso_o, miso_oe;
  logic        sclk_i = 1'b0, ssel_i = 1'b1, mosi_i = 1'b0, miso_i = 1'b0;

  int checks = 0, errors = 0;
  bit finished = 0;

  // bench-side monitor state
  logic       tb_pol = 0, tb_pha = 0, mon_clr = 0;
  logic       prev_sclk = 0;
  logic [7:0] mon = '0;
  int         mon_n = 0, cyc = 0, t_first = -1, t_gap = -1;
  bit         saw_low = 0;

  always #4 clk = ~clk;

  spi_port_ctrl dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .done(done), .sclk_o(sclk_o), .mosi_o(mosi_o), .ssel_o(ssel_o),
    .mst_oe(mst_oe), .sclk_i(sclk_i), .ssel_i(ssel_i), .mosi_i(mosi_i), .miso_i(miso_i),
    .miso_o(miso_o), .miso_oe(miso_oe)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    prev_sclk <= sclk_o;
    if (mon_clr) begin
      mon <= '0; mon_n <= 0; saw_low <= 0; t_first <= -1; t_gap <= -1;
    end else begin
      if (!ssel_o) saw_low <= 1;
      if (!ssel_o && sclk_o != prev_sclk) begin
        if (t_first < 0) t_first <= cyc;
        else if (t_gap < 0) t_gap <= cyc - t_first;
        if ((prev_sclk == tb_pol) ^ tb_pha) begin
          mon   <= {mon[6:0], mosi_o};
          mon_n <= mon_n + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic clear_mon();
    @(negedge clk); mon_clr = 1;
    @(negedge clk); mon_clr = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000 && !done; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk(ssel_o == 1 && miso_oe == 0 && mst_oe == 0 && done == 0, "R1 pins", {ssel_o, miso_oe, mst_oe, done}, 4'b1000);
    for (int a = 0; a < 5; a++) begin
      rd_reg(3'(a), d);
      chk(d == ((a == 2) ? 16'd2 : 16'd0), "R1 reg", d, (a == 2) ? 2 : 0);
    end
  endtask

  task automatic t_psc();
    logic [15:0] d;
    wr_reg(2, 16'd7); rd_reg(2, d); chk(d == 16'd6, "R2 odd", d, 6);
    wr_reg(2, 16'd1); rd_reg(2, d); chk(d == 16'd2, "R2 one", d, 2);
    wr_reg(2, 16'd0); rd_reg(2, d); chk(d == 16'd2, "R2 zero", d, 2);
  endtask

  task automatic t_reserved();
    logic [15:0] d;
    wr_reg(1, 16'hFFF0); rd_reg(1, d); chk(d == 16'h0, "R3 ctrl", d, 0);
    wr_reg(0, 16'h00FC); rd_reg(0, d); chk(d == 16'h0, "R3 mode", d, 0);
  endtask

  task automatic t_lock();
    logic [15:0] d;
    wr_reg(1, 16'h0002); wr_reg(1, 16'h0006); rd_reg(1, d);
    chk(d[2] == 0, "R8 set while enabled", d, 2);
    wr_reg(1, 16'h0000); wr_reg(1, 16'h0004); rd_reg(1, d);
    chk(d[2] == 1, "R8 set while disabled", d, 4);
    wr_reg(1, 16'h0006); wr_reg(1, 16'h0002); rd_reg(1, d);
    chk(d[2] == 1, "R8 clear while enabled", d, 6);
    wr_reg(1, 16'h0000); wr_reg(1, 16'h0000);
  endtask

  task automatic run_master(input bit pol, input bit pha, input bit loop, input bit miso_v,
                            input logic [7:0] tx, input logic [7:0] exp_rx, input string tag);
    logic [15:0] d;
    wr_reg(1, 16'h0000);
    wr_reg(0, {8'h00, 6'b0, pha, pol});
    tb_pol = pol; tb_pha = pha; miso_i = miso_v;
    wr_reg(1, {14'b0, 1'b1, loop});
    clear_mon();
    chk(sclk_o == pol, {tag, " R5 idle before"}, sclk_o, pol);
    wr_reg(3, {8'h00, tx});
    wait_done();
    @(negedge clk);
    chk(done == 1 && ssel_o == 1 && saw_low, {tag, " R4 frame"}, {done, ssel_o, saw_low}, 3'b111);
    chk(mon == tx && mon_n == 8, {tag, " R4 R5 mosi bits"}, mon, tx);
    chk(sclk_o == pol, {tag, " R5 idle after"}, sclk_o, pol);
    rd_reg(3, d);
    chk(d[7:0] == exp_rx, {tag, " R7 R12 rx"}, d, exp_rx);
  endtask

  task automatic t_rate();
    wr_reg(1, 16'h0000);
    wr_reg(2, 16'd4);
    wr_reg(0, 16'h0200);
    tb_pol = 0; tb_pha = 0;
    wr_reg(1, 16'h0003);
    clear_mon();
    wr_reg(3, 16'h005A);
    wait_done();
    chk(t_gap == 6, "R6 half period", t_gap, 6);
    wr_reg(1, 16'h0000);
    wr_reg(2, 16'd2);
    wr_reg(0, 16'h0000);
  endtask

  task automatic t_disabled();
    wr_reg(1, 16'h0000);
    clear_mon();
    wr_reg(3, 16'h00C3);
    repeat (40) @(negedge clk);
    chk(!saw_low && ssel_o && !done && !miso_oe, "R11 disabled", {saw_low, ssel_o, done, miso_oe}, 4'b0100);
  endtask

  task automatic run_slave(input bit pol, input bit pha, input bit loop, input bit odis,
                           input logic [7:0] tx, input logic [7:0] mb, input logic [7:0] exp_rx,
                           input string tag);
    logic [15:0] d;
    logic [7:0]  mis;
    bit          oe_seen;
    oe_seen = 0; mis = '0;
    wr_reg(1, 16'h0000);
    sclk_i = pol; ssel_i = 1;
    wr_reg(1, 16'h0004);
    wr_reg(0, {14'b0, pha, pol});
    tb_pha = pha;
    wr_reg(3, {8'h00, tx});
    wr_reg(1, {12'b0, odis, 1'b1, 1'b1, loop});
    repeat (6) @(negedge clk);
    ssel_i = 0;
    repeat (8) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      if (!pha) begin
        mosi_i = mb[i];
        repeat (8) @(negedge clk);
        mis[i] = miso_o; oe_seen |= miso_oe;
        sclk_i = ~sclk_i;
        repeat (8) @(negedge clk);
        sclk_i = ~sclk_i;
      end else begin
        repeat (8) @(negedge clk);
        sclk_i = ~sclk_i; mosi_i = mb[i];
        repeat (8) @(negedge clk);
        mis[i] = miso_o; oe_seen |= miso_oe;
        sclk_i = ~sclk_i;
      end
    end
    repeat (8) @(negedge clk);
    ssel_i = 1;
    repeat (8) @(negedge clk);
    chk(done == 1, {tag, " R9 done"}, done, 1);
    rd_reg(3, d);
    chk(d[7:0] == exp_rx, {tag, " R9 R7 rx"}, d, exp_rx);
    if (odis) chk(!oe_seen, {tag, " R10 no drive"}, oe_seen, 0);
    else      chk(oe_seen && mis == tx, {tag, " R9 miso bits"}, mis, tx);
    wr_reg(1, 16'h0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_psc();
    t_reserved();
    t_lock();
    run_master(0, 0, 1, 0, 8'hA5, 8'hA5, "mode0 loop");
    run_master(0, 1, 1, 0, 8'h3C, 8'h3C, "mode1 loop");
    run_master(1, 0, 1, 0, 8'h81, 8'h81, "mode2 loop");
    run_master(1, 1, 1, 0, 8'h6E, 8'h6E, "mode3 loop");
    run_master(0, 0, 0, 1, 8'h12, 8'hFF, "pin high");
    run_master(1, 1, 0, 0, 8'hF0, 8'h00, "pin low");
    t_rate();
    t_disabled();
    run_slave(0, 0, 0, 0, 8'hC9, 8'h5B, 8'h5B, "slave m0");
    run_slave(1, 1, 0, 0, 8'h2D, 8'hE4, 8'hE4, "slave m3");
    run_slave(0, 1, 1, 0, 8'h96, 8'h69, 8'h96, "slave loop");
    run_slave(1, 0, 0, 1, 8'h77, 8'h1E, 8'h1E, "slave odis");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule